// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Lock

This block turns a start/data/stop serial stream on one input pin into bytes (or 9-bit words) that a host pulls from a small register port. A programmable divisor sets the oversampling tick. A speed-select bit changes the number of ticks per bit from 16 to 4. Each bit is decided by a majority vote of three ticks around its middle. Finished words enter a two-entry receive queue. Each entry keeps its own ninth bit and its own stop-bit error.

The host enables the serial port and then enables reception separately. It waits for the ready flag or the interrupt. It reads the status register, which gives the ninth bit and the framing error of the oldest word. It then reads the data register, and that read removes the word from the queue.

If a word finishes while the queue is full, the overrun flag is set. The receiver then stores nothing until the host clears the receive-enable bit. Words already queued can still be read while the overrun flag is set.

Top module: `async_rx`

## Requirements
- R1: After reset the control register (address 0), the status register (address 1) and the divisor register (address 3) all read 0, and `irq` is low.
- R2: Each frame is one low start bit, then 8 data bits sent least significant bit first, then a stop bit. When port enable (control bit 0) and receive enable (control bit 1) are both set, the data bits of a received frame are read at address 2.
- R3: If either port enable or receive enable is clear, frames on `rx` are not stored, and the ready flag (status bit 0) stays 0.
- R4: One bit lasts (divisor+1)×16 clock cycles. With the speed-select bit (control bit 3) set, one bit lasts (divisor+1)×4 clock cycles.
- R5: With the 9-bit select (control bit 2) set, each frame carries 9 data bits. The ninth bit of the oldest queued word reads at status bit 1, and its low 8 bits read at address 2. In 8-bit mode status bit 1 reads 0.
- R6: A stop bit sampled low still stores the word, and sets status bit 2 (framing error) for that word only.
- R7: The queue holds two words. Each read of address 2 returns the oldest word and removes it.
- R8: Status bit 0 is 1 whenever the queue holds a word and drops once the last word is read. `irq` equals that flag ANDed with the interrupt enable (control bit 4).
- R9: A word that finishes while both queue entries are full is dropped and sets status bit 3 (overrun). While overrun is set, no further word is stored, and the words already queued stay readable.
- R10: Clearing receive enable clears overrun. After receive enable is set again, new frames are stored.
- R11: A low pulse on `rx` that is gone by the middle of the start bit does not start a frame, and no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Serial data in, idle high |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 divisor |
| wr_en | input | 1 | Write strobe for control and divisor |
| rd_en | input | 1 | Read strobe; at address 2 removes the oldest word |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | Receive-ready interrupt |

## Verification
Bytes with alternating and grouped bit patterns are received at both the 16-tick and the 4-tick rate. A wrong bit order or a wrong oversampling count garbles these patterns, so they expose both faults. Nine-bit frames are sent with the top bit set and with it clear, and one frame is sent with a low stop bit. These frames show whether the per-entry flags follow the correct word through the queue. Back-to-back frames without reads separate correct two-deep queuing from early or late overrun. Further frames sent during overrun, and again after the enable toggle, show whether the receiver locks and then recovers. A short low glitch and frames sent with either enable clear must leave the queue empty.

// File: rtl/async_rx.sv
module async_rx #(
  parameter int DIVW    = 8,
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 4,
  parameter int DEPTH   = 2   // power of two
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx,
  input  logic [1:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            irq
);

  localparam int OSW = $clog2(OS_NORM);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam logic [OSW-1:0] ONE = OSW'(1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [7:0]      ctl_q;
  logic [DIVW-1:0] div_q, brg_q;
  logic [1:0]      sync_q;
  logic            prev_q;
  st_t             st_q;
  logic [OSW-1:0]  os_q;
  logic [3:0]      nb_q;
  logic [2:0]      vote_q;
  logic [8:0]      sh_q;
  logic [9:0]      ent_q [DEPTH];
  logic [PW-1:0]   rp_q;
  logic [CW-1:0]   cnt_q;
  logic            ovr_q;

  logic port_en, rx_on, nine, fast, ie;
  assign port_en = ctl_q[0];
  assign rx_on   = ctl_q[1];
  assign nine    = ctl_q[2];
  assign fast    = ctl_q[3];
  assign ie      = ctl_q[4];

  logic run, tick, smp;
  assign run  = port_en & rx_on;
  assign tick = run && (brg_q == div_q);
  assign smp  = sync_q[1];

  logic [OSW-1:0] os_last, os_mid;
  assign os_last = fast ? OSW'(OS_FAST - 1) : OSW'(OS_NORM - 1);
  assign os_mid  = fast ? OSW'(OS_FAST / 2) : OSW'(OS_NORM / 2);

  logic       in_win, maj_n;
  logic [2:0] vote_n;
  assign in_win = (os_q == os_mid - ONE) || (os_q == os_mid) || (os_q == os_mid + ONE);
  assign vote_n = in_win ? {vote_q[1:0], smp} : vote_q;
  assign maj_n  = (vote_n[0] & vote_n[1]) | (vote_n[0] & vote_n[2]) | (vote_n[1] & vote_n[2]);

  logic [3:0] last_bit;
  assign last_bit = nine ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      if (addr == 2'd0) ctl_q <= wdata;
      if (addr == 2'd3) div_q <= wdata[DIVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     sync_q <= 2'b11;
    else                            sync_q <= {sync_q[0], rx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     brg_q <= '0;
    else if (!run || tick)          brg_q <= '0;
    else                            brg_q <= brg_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      os_q   <= '0;
      nb_q   <= '0;
      vote_q <= 3'b111;
      sh_q   <= '0;
      prev_q <= 1'b1;
    end else if (!run) begin
      st_q   <= S_IDLE;
      os_q   <= '0;
      prev_q <= 1'b1;
    end else if (tick) begin
      prev_q <= smp;
      vote_q <= vote_n;
      case (st_q)
        S_IDLE: if (prev_q && !smp) begin
          st_q <= S_START;
          os_q <= '0;
        end
        S_START: if (os_q == os_last) begin
          os_q <= '0;
          nb_q <= '0;
          st_q <= maj_n ? S_IDLE : S_DATA;
        end else os_q <= os_q + ONE;
        S_DATA: if (os_q == os_last) begin
          os_q <= '0;
          sh_q <= {maj_n, sh_q[8:1]};
          nb_q <= nb_q + 4'd1;
          if (nb_q == last_bit) st_q <= S_STOP;
        end else os_q <= os_q + ONE;
        S_STOP: if (os_q == os_mid + ONE) begin
          os_q <= '0;
          st_q <= S_IDLE;
        end else os_q <= os_q + ONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic       push_req, pop, room, accept;
  logic [7:0] data8;
  logic       b8;
  logic [PW-1:0] wp;
  assign push_req = tick && (st_q == S_STOP) && (os_q == os_mid + ONE);
  assign data8    = nine ? sh_q[7:0] : sh_q[8:1];
  assign b8       = nine & sh_q[8];
  assign pop      = rd_en && (addr == 2'd2) && (cnt_q != '0);
  assign room     = (cnt_q != CW'(DEPTH)) || pop;
  assign accept   = push_req && !ovr_q && room;
  assign wp       = rp_q + PW'(cnt_q);

  always_ff @(posedge clk) begin
    if (accept) ent_q[wp] <= {!maj_n, b8, data8};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else if (!port_en) begin
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (!rx_on)                          ovr_q <= 1'b0;
      else if (push_req && !ovr_q && !room) ovr_q <= 1'b1;
      if (pop) rp_q <= rp_q + 1'b1;
      case ({accept, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  logic       ready;
  logic [9:0] head;
  assign ready = (cnt_q != '0);
  assign head  = ready ? ent_q[rp_q] : 10'd0;
  assign irq   = ie & ready;

  always_comb begin
    case (addr)
      2'd0:    rdata = ctl_q;
      2'd1:    rdata = {4'd0, ovr_q, head[9], head[8], ready};
      2'd2:    rdata = head[7:0];
      default: rdata = 8'(div_q);
    endcase
  end

endmodule

module async_rx_chk #(
  parameter int CW    = 2,
  parameter int DEPTH = 2
)(
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          ovr,
  input logic          port_en,
  input logic          rx_on,
  input logic          push,
  input logic          pop,
  input logic          irq
);

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r9_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt == CW'(DEPTH) && !pop && port_en && rx_on) |=> ovr);

  a_r9_frozen_queue: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> cnt <= $past(cnt));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> (ovr || !rx_on || !port_en));

  a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt == CW'(1) && !push) |=> !irq);

endmodule

bind async_rx async_rx_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .ovr(ovr_q),
  .port_en(ctl_q[0]), .rx_on(ctl_q[1]), .push(push_req), .pop(pop), .irq(irq)
);

// File: tb/async_rx_tb.sv
module async_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  logic [9:0] exp_q [$];

  always #4 clk = ~clk;

  async_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  // driver: serializes a frame and pushes the expected word into the scoreboard
  task automatic send(input logic [8:0] d, input int nb, input logic stop,
                      input int bclk, input logic keep);
    @(negedge clk);
    rx = 1'b0;
    repeat (bclk) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx = d[i];
      repeat (bclk) @(negedge clk);
    end
    rx = stop;
    repeat (bclk) @(negedge clk);
    rx = 1'b1;
    repeat (2 * bclk) @(negedge clk);
    if (keep) exp_q.push_back({~stop, (nb == 9) ? d[8] : 1'b0, d[7:0]});
  endtask

  // monitor: pops the oldest expected word and compares status flags and data
  task automatic take(input string req);
    logic [7:0] st, dt;
    logic [9:0] e;
    if (exp_q.size() == 0) begin
      chk({req, " scoreboard empty"}, 1, 0);
      return;
    end
    e = exp_q.pop_front();
    rd(2'd1, st);
    chk({req, " ready"}, int'(st[0]), 1);
    chk({req, " ninth bit"}, int'(st[1]), int'(e[8]));
    chk({req, " framing"}, int'(st[2]), int'(e[9]));
    rd(2'd2, dt);
    chk({req, " data"}, int'(dt), int'(e[7:0]));
    @(negedge clk);
    addr = 2'd2; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk("R1 control", int'(v), 0);
    rd(2'd1, v); chk("R1 status", int'(v), 0);
    rd(2'd3, v); chk("R1 divisor", int'(v), 0);
    chk("R1 irq", int'(irq), 0);

    // R2, R8: 8-bit frame at 16 ticks per bit, divisor 1 -> 32 clocks per bit
    wr(2'd3, 8'd1);
    wr(2'd0, 8'h13);
    send(9'h0A5, 8, 1'b1, 32, 1'b1);
    chk("R8 irq set", int'(irq), 1);
    take("R2");
    rd(2'd1, v); chk("R8 ready cleared", int'(v[0]), 0);
    chk("R8 irq cleared", int'(irq), 0);

    // R3: either enable clear blocks reception
    wr(2'd0, 8'h01);
    send(9'h03C, 8, 1'b1, 32, 1'b0);
    rd(2'd1, v); chk("R3 rx enable off", int'(v[0]), 0);
    wr(2'd0, 8'h02);
    send(9'h03C, 8, 1'b1, 32, 1'b0);
    rd(2'd1, v); chk("R3 port enable off", int'(v[0]), 0);

    // R11: short glitch ignored
    wr(2'd0, 8'h13);
    @(negedge clk); rx = 1'b0;
    repeat (2) @(negedge clk); rx = 1'b1;
    repeat (64) @(negedge clk);
    rd(2'd1, v); chk("R11 glitch", int'(v[0]), 0);
    chk("R11 irq", int'(irq), 0);

    // R4: fast mode, divisor 3 -> 16 clocks per bit
    wr(2'd3, 8'd3);
    wr(2'd0, 8'h1B);
    send(9'h096, 8, 1'b1, 16, 1'b1);
    take("R4 fast");
    wr(2'd3, 8'd1);
    wr(2'd0, 8'h13);
    send(9'h0E1, 8, 1'b1, 32, 1'b1);
    take("R4 normal");

    // R5: 9-bit mode
    wr(2'd0, 8'h17);
    send(9'h1C3, 9, 1'b1, 32, 1'b1);
    take("R5 ninth set");
    send(9'h0F0, 9, 1'b1, 32, 1'b1);
    take("R5 ninth clear");

    // R6: framing error on low stop bit, next word clean
    wr(2'd0, 8'h13);
    send(9'h055, 8, 1'b0, 32, 1'b1);
    send(9'h0AA, 8, 1'b1, 32, 1'b1);
    take("R6 bad stop");
    take("R6 following word");

    // R7: two words queued, read in order
    send(9'h011, 8, 1'b1, 32, 1'b1);
    send(9'h022, 8, 1'b1, 32, 1'b1);
    rd(2'd1, v); chk("R7 no overrun at two", int'(v[3]), 0);
    take("R7 first");
    take("R7 second");

    // R9: third word overruns and is dropped
    send(9'h031, 8, 1'b1, 32, 1'b1);
    send(9'h032, 8, 1'b1, 32, 1'b1);
    send(9'h033, 8, 1'b1, 32, 1'b0);
    rd(2'd1, v); chk("R9 overrun set", int'(v[3]), 1);
    take("R9 kept first");
    take("R9 kept second");
    rd(2'd1, v); chk("R9 third dropped", int'(v[0]), 0);
    send(9'h044, 8, 1'b1, 32, 1'b0);
    rd(2'd1, v); chk("R9 locked ready", int'(v[0]), 0);
    chk("R9 locked overrun", int'(v[3]), 1);

    // R10: toggle receive enable to recover
    wr(2'd0, 8'h11);
    rd(2'd1, v); chk("R10 overrun cleared", int'(v[3]), 0);
    wr(2'd0, 8'h13);
    send(9'h05A, 8, 1'b1, 32, 1'b1);
    take("R10 resumed");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule